// File: doc/BRIEF.md
# Three-Wire Configuration Register Slave

This block is a serial slave that holds eight configuration registers for an analog front end. A host reaches it over three wires: a serial clock, a serial data input, and an active-low load strobe. The read data comes back on a separate output with its own enable, and the pad can tri-state on that enable. Every wire is brought into the system clock domain through a two-stage synchronizer. The serial clock must therefore stay well below the system clock; a serial half period of at least four system clocks is assumed.

A frame begins when the strobe goes low. The host then clocks in a direction bit, a test bit, a three-bit address and up to eleven data bits. Address and data are both sent least-significant bit first. A write frame places each data bit into a staging (shadow) copy of the addressed register as that bit arrives. The configuration outputs change only when the strobe returns high. A read frame sends the addressed register's current output value back, one bit per serial-clock falling edge, once the header is complete.

Top module: `sri_slave`

## Requirements
- R1: After reset every configuration output is zero, except operation bit 7, which reads 1. `sdo_en` is low after reset.
- R2: While `sl_n` is low, bits are taken on rising `sck` edges in this order: direction (0 = write, 1 = read), test bit, address bits 0..2, then data bits 0..10. The address selects operation (0), gain (1), clamp (2), control (3) and the four stage-gain registers (4..7).
- R3: A write leaves every configuration output unchanged while `sl_n` stays low. Within 5 system clocks after `sl_n` rises, the addressed output shows the written data.
- R4: A frame whose test bit is 1 changes no register and never raises `sdo_en`.
- R5: Register widths are 8 bits for operation, 10 for gain, 8 for clamp, 10 for control and 6 for each stage gain. Data bits above a register's width are ignored on write.
- R6: Operation bits 5 and 6 always read 0 and bit 7 always reads 1, whatever was written. Operation bits 4..0 are writable.
- R7: A write frame that stops after k data bits (k from 0 to 10) updates only data bits 0..k-1 of the addressed register. Its other bits keep their earlier staged values.
- R8: A frame of fewer than five bits commits nothing.
- R9: In a read frame, `sdo_en` rises after the fifth falling `sck` edge and `sdo` carries data bit 0. Each later falling edge presents the next bit. Bits above the register's width read 0.
- R10: `sdo_en` is low whenever `sl_n` is high.
- R11: A read frame changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from host |
| sl_n | input | 1 | Active-low frame/load strobe |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial read data |
| sdo_en | output | 1 | Drive enable for the read data pad |
| op_cfg | output | 8 | Operation register output |
| gain_cfg | output | 10 | Gain register output |
| clamp_cfg | output | 8 | Clamp level register output |
| ctrl_cfg | output | 10 | Control register output |
| pga_cfg | output | 24 | Four 6-bit stage gains, register 4+k at bits 6k+5..6k |

## Verification
A serial clock edge reaches the frame logic after two synchronizer flops and one edge register. A read bit appears on `sdo` about four system clocks after its falling `sck` edge, and the bench samples `sdo` eight clocks after that edge, just before the next rising edge. A commit appears on the outputs four system clocks after `sl_n` rises, and the bench compares all outputs eight clocks after the rise. Before raising the strobe, the bench also compares the outputs against the values from before the frame.

// File: rtl/sri_pkg.sv
// Shared constants, types and register-map helpers for the serial slave.
// Assumes eight registers with an 11-bit data field and LSB-first framing.
package sri_pkg;
    localparam int NREG       = 8;
    localparam int ADDR_W     = 3;
    localparam int DATA_W     = 11;
    localparam int HDR_BITS   = 5;
    localparam int FRAME_BITS = HDR_BITS + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int IDX_W      = $clog2(DATA_W);

    localparam int OP_W    = 8;
    localparam int GAIN_W  = 10;
    localparam int CLAMP_W = 8;
    localparam int CTRL_W  = 10;
    localparam int PGA_W   = 6;
    localparam int NPGA    = 4;
    localparam int PGA_BASE = 4;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // Forced bits of the operation register: bits 5,6 low, bit 7 high.
    localparam word_t OP_FIX_MASK = 11'h0E0;
    localparam word_t OP_FIX_VAL  = 11'h080;

    // One staged data bit travelling from the frame decoder to the bank.
    typedef struct packed {
        logic             valid;
        addr_t            addr;
        logic [IDX_W-1:0] bit_idx;
        logic             value;
    } wr_bit_t;

    function automatic int reg_width(int idx);
        case (idx)
            0:       return OP_W;
            1:       return GAIN_W;
            2:       return CLAMP_W;
            3:       return CTRL_W;
            default: return PGA_W;
        endcase
    endfunction

    function automatic word_t width_mask(int idx);
        return word_t'((32'd1 << reg_width(idx)) - 32'd1);
    endfunction

    function automatic word_t fix_mask(int idx);
        return (idx == 0) ? OP_FIX_MASK : '0;
    endfunction

    function automatic word_t fix_val(int idx);
        return (idx == 0) ? OP_FIX_VAL : '0;
    endfunction
endpackage

// File: rtl/sri_sync.sv
// Two-flop synchronizer for a bundle of asynchronous inputs.
// Assumes every bit is sampled independently; RST_VAL gives each bit's idle level.
module sri_sync #(
    parameter int               WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta_q;

    // Two-stage capture into the system clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/sri_frame.sv
// Frame decoder: finds serial clock and strobe edges, counts bits, and
// captures the header. It issues per-bit shadow writes, commit requests and
// readout controls. Assumes synchronized inputs and a slow serial clock.
module sri_frame
    import sri_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sck_s,
    input  logic    sl_n_s,
    input  logic    sdi_s,
    output logic    frame_active,
    output logic    sck_fall,
    output wr_bit_t wr,
    output logic    commit_vld,
    output addr_t   commit_addr,
    output addr_t   hdr_addr,
    output logic    rd_start,
    output logic    rd_shift
);
    logic             sck_q;
    logic             sl_q;
    logic             sck_rise;
    logic             sl_rise;
    logic [CNT_W-1:0] cnt_q;
    logic             rnw_q;
    logic             test_q;
    addr_t            addr_q;
    logic             in_data;
    logic             hdr_done;

    localparam logic [CNT_W-1:0] HDR_CNT   = CNT_W'(HDR_BITS);
    localparam logic [CNT_W-1:0] FRAME_CNT = CNT_W'(FRAME_BITS);

    // Previous-cycle copies used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            sl_q  <= 1'b1;
        end else begin
            sck_q <= sck_s;
            sl_q  <= sl_n_s;
        end
    end

    assign sck_rise     = sck_s & ~sck_q;
    assign sck_fall     = ~sck_s & sck_q;
    assign sl_rise      = sl_n_s & ~sl_q;
    assign frame_active = ~sl_n_s;
    assign in_data      = (cnt_q >= HDR_CNT) && (cnt_q != FRAME_CNT);
    assign hdr_done     = (cnt_q >= HDR_CNT);

    // Bit counter and header capture; counter clears whenever the strobe is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            rnw_q  <= 1'b0;
            test_q <= 1'b0;
            addr_q <= '0;
        end else if (!frame_active) begin
            cnt_q <= '0;
        end else if (sck_rise && (cnt_q != FRAME_CNT)) begin
            cnt_q <= cnt_q + 1'b1;
            case (cnt_q)
                CNT_W'(0): rnw_q  <= sdi_s;
                CNT_W'(1): test_q <= sdi_s;
                CNT_W'(2), CNT_W'(3), CNT_W'(4): addr_q <= {sdi_s, addr_q[ADDR_W-1:1]};
                default: ;
            endcase
        end
    end

    // Per-bit staging write for data bits of a valid write frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr <= '0;
        end else begin
            wr.valid   <= frame_active && sck_rise && in_data && !rnw_q && !test_q;
            wr.addr    <= addr_q;
            wr.bit_idx <= IDX_W'(cnt_q - HDR_CNT);
            wr.value   <= sdi_s;
        end
    end

    // Commit request when the strobe rises after a complete write header.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_vld  <= 1'b0;
            commit_addr <= '0;
        end else begin
            commit_vld  <= sl_rise && hdr_done && !rnw_q && !test_q;
            commit_addr <= addr_q;
        end
    end

    assign hdr_addr = addr_q;
    assign rd_start = frame_active && sck_fall && (cnt_q == HDR_CNT) && rnw_q && !test_q;
    assign rd_shift = frame_active && sck_fall && (cnt_q > HDR_CNT);
endmodule

// File: rtl/sri_regbank.sv
// Register bank: one shadow and one active copy per address, built by generate.
// Shadow bits take single-bit writes. The active copy loads from the shadow on
// commit. Outputs carry the width mask and the forced operation bits.
module sri_regbank
    import sri_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  wr_bit_t                        wr,
    input  logic                           commit_vld,
    input  addr_t                          commit_addr,
    input  addr_t                          rd_addr,
    output logic [NREG-1:0][DATA_W-1:0]    act_o,
    output word_t                          rd_data
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam word_t            WMASK = width_mask(g);
        localparam word_t            FMASK = fix_mask(g);
        localparam word_t            FVAL  = fix_val(g);
        localparam logic [IDX_W-1:0] WLIM  = IDX_W'(reg_width(g));
        localparam addr_t            MYADDR = ADDR_W'(g);

        word_t shadow_q;
        word_t active_q;

        // Staging register: take one data bit when it targets this address.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_q <= '0;
            end else if (wr.valid && (wr.addr == MYADDR) && (wr.bit_idx < WLIM)) begin
                shadow_q[wr.bit_idx] <= wr.value;
            end
        end

        // Active register: load the staged value on a commit to this address.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                active_q <= '0;
            end else if (commit_vld && (commit_addr == MYADDR)) begin
                active_q <= shadow_q & WMASK;
            end
        end

        assign act_o[g] = (active_q & WMASK & ~FMASK) | FVAL;
    end

    assign rd_data = act_o[rd_addr];
endmodule

// File: rtl/sri_readout.sv
// Read shifter: loads the addressed register at readout start, shifts on later
// falling serial clock edges, and drives the enable only inside the frame.
module sri_readout
    import sri_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  frame_active,
    input  logic  rd_start,
    input  logic  rd_shift,
    input  word_t rd_data,
    output logic  sdo,
    output logic  sdo_en
);
    word_t sh_q;
    logic  oe_q;

    // Load, shift and release of the readback word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
            oe_q <= 1'b0;
        end else if (!frame_active) begin
            sh_q <= '0;
            oe_q <= 1'b0;
        end else if (rd_start) begin
            sh_q <= rd_data;
            oe_q <= 1'b1;
        end else if (rd_shift && oe_q) begin
            sh_q <= {1'b0, sh_q[DATA_W-1:1]};
        end
    end

    assign sdo    = oe_q & sh_q[0];
    assign sdo_en = oe_q;
endmodule

// File: rtl/sri_slave.sv
// Top of the three-wire configuration slave. Synchronizes the serial wires,
// decodes frames, holds the staged register bank and returns read data.
// Assumes the serial half period spans at least four system clocks.
module sri_slave
    import sri_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sck,
    input  logic                    sl_n,
    input  logic                    sdi,
    output logic                    sdo,
    output logic                    sdo_en,
    output logic [OP_W-1:0]         op_cfg,
    output logic [GAIN_W-1:0]       gain_cfg,
    output logic [CLAMP_W-1:0]      clamp_cfg,
    output logic [CTRL_W-1:0]       ctrl_cfg,
    output logic [NPGA*PGA_W-1:0]   pga_cfg
);
    logic                        sck_s;
    logic                        sl_n_s;
    logic                        sdi_s;
    logic                        frame_active;
    logic                        sck_fall;
    wr_bit_t                     wr;
    logic                        commit_vld;
    addr_t                       commit_addr;
    addr_t                       hdr_addr;
    logic                        rd_start;
    logic                        rd_shift;
    logic [NREG-1:0][DATA_W-1:0] act;
    word_t                       rd_data;

    sri_sync #(.WIDTH(3), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck, sl_n, sdi}),
        .q     ({sck_s, sl_n_s, sdi_s})
    );

    sri_frame u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .sck_s        (sck_s),
        .sl_n_s       (sl_n_s),
        .sdi_s        (sdi_s),
        .frame_active (frame_active),
        .sck_fall     (sck_fall),
        .wr           (wr),
        .commit_vld   (commit_vld),
        .commit_addr  (commit_addr),
        .hdr_addr     (hdr_addr),
        .rd_start     (rd_start),
        .rd_shift     (rd_shift)
    );

    sri_regbank u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (wr),
        .commit_vld  (commit_vld),
        .commit_addr (commit_addr),
        .rd_addr     (hdr_addr),
        .act_o       (act),
        .rd_data     (rd_data)
    );

    sri_readout u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_active (frame_active),
        .rd_start     (rd_start),
        .rd_shift     (rd_shift),
        .rd_data      (rd_data),
        .sdo          (sdo),
        .sdo_en       (sdo_en)
    );

    assign op_cfg    = act[0][OP_W-1:0];
    assign gain_cfg  = act[1][GAIN_W-1:0];
    assign clamp_cfg = act[2][CLAMP_W-1:0];
    assign ctrl_cfg  = act[3][CTRL_W-1:0];

    for (genvar k = 0; k < NPGA; k++) begin : g_pga
        assign pga_cfg[k*PGA_W +: PGA_W] = act[PGA_BASE+k][PGA_W-1:0];
    end
endmodule

// File: rtl/sri_slave_chk.sv
// Property checker for the serial slave, attached to the top by bind.
// Observes internal decode strobes against the block outputs.
module sri_slave_chk
    import sri_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  frame_active,
    input logic                  sck_fall,
    input logic                  commit_vld,
    input logic                  sdo_en,
    input logic [OP_W-1:0]       op_cfg,
    input logic [GAIN_W-1:0]     gain_cfg,
    input logic [CLAMP_W-1:0]    clamp_cfg,
    input logic [CTRL_W-1:0]     ctrl_cfg,
    input logic [NPGA*PGA_W-1:0] pga_cfg
);
    // R10: enable drops once the strobe is seen high.
    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_active |=> !sdo_en);

    // R9: the read driver turns on only right after a falling serial clock edge.
    assert_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_en) |-> $past(sck_fall));

    // R3: outputs hold unless a commit was issued.
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_vld |=> $stable({op_cfg, gain_cfg, clamp_cfg, ctrl_cfg, pga_cfg}));

    // R6: forced operation bits.
    assert_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op_cfg[7:5] == 3'b100);
endmodule

bind sri_slave sri_slave_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_active (frame_active),
    .sck_fall     (sck_fall),
    .commit_vld   (commit_vld),
    .sdo_en       (sdo_en),
    .op_cfg       (op_cfg),
    .gain_cfg     (gain_cfg),
    .clamp_cfg    (clamp_cfg),
    .ctrl_cfg     (ctrl_cfg),
    .pga_cfg      (pga_cfg)
);

// File: tb/sri_slave_tb.sv
// Bench: directed corners plus seeded random frames checked against a model.
module sri_slave_tb_top;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        sl_n = 1'b1;
    logic        sdi = 1'b0;
    logic        sdo, sdo_en;
    logic [7:0]  op_cfg;
    logic [9:0]  gain_cfg;
    logic [7:0]  clamp_cfg;
    logic [9:0]  ctrl_cfg;
    logic [23:0] pga_cfg;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [10:0] sh_m  [8];
    logic [10:0] act_m [8];

    always #10 clk = ~clk;

    sri_slave dut_i (
        .clk(clk), .rst_n(rst_n), .sck(sck), .sl_n(sl_n), .sdi(sdi),
        .sdo(sdo), .sdo_en(sdo_en), .op_cfg(op_cfg), .gain_cfg(gain_cfg),
        .clamp_cfg(clamp_cfg), .ctrl_cfg(ctrl_cfg), .pga_cfg(pga_cfg)
    );

    function automatic int wid(int a);
        case (a)
            0: return 8;
            1: return 10;
            2: return 8;
            3: return 10;
            default: return 6;
        endcase
    endfunction

    function automatic logic [10:0] view(int a);
        logic [10:0] v;
        v = act_m[a] & 11'((32'd1 << wid(a)) - 1);
        if (a == 0) v = (v & ~11'h0E0) | 11'h080;
        return v;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_outputs(string req);
        logic [10:0] v;
        v = view(0); chk(req, "op_cfg",    32'(op_cfg),    32'(v[7:0]));
        v = view(1); chk(req, "gain_cfg",  32'(gain_cfg),  32'(v[9:0]));
        v = view(2); chk(req, "clamp_cfg", 32'(clamp_cfg), 32'(v[7:0]));
        v = view(3); chk(req, "ctrl_cfg",  32'(ctrl_cfg),  32'(v[9:0]));
        for (int g = 0; g < 4; g++) begin
            v = view(4 + g);
            chk(req, "pga_cfg", 32'(pga_cfg[g*6 +: 6]), 32'(v[5:0]));
        end
    endtask

    // Drive one frame, compare outputs, and update the model.
    task automatic frame(bit rnw, bit test, int a, logic [10:0] d, int nbits, string req);
        logic [10:0] rd_bits;
        logic [10:0] en_bits;
        logic [10:0] exp_rd;
        int          recv;
        rd_bits = '0;
        en_bits = '0;
        exp_rd  = view(a);
        @(negedge clk) sl_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            if (i == 0)      sdi = rnw;
            else if (i == 1) sdi = test;
            else if (i < 5)  sdi = 1'(a >> (i - 2));
            else             sdi = d[i-5];
            repeat (HALF) @(negedge clk);
            if (i >= 5) begin
                rd_bits[i-5] = sdo;
                en_bits[i-5] = sdo_en;
            end
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        check_outputs({req, "/R3-hold"});
        sl_n = 1'b1;
        repeat (8) @(negedge clk);
        recv = (nbits > 5) ? nbits - 5 : 0;
        if (rnw && !test) begin
            for (int j = 0; j < recv; j++) begin
                chk({req, "/R9"}, $sformatf("rd bit %0d", j), 32'(rd_bits[j]), 32'(exp_rd[j]));
                chk({req, "/R9"}, $sformatf("en bit %0d", j), 32'(en_bits[j]), 32'd1);
            end
        end else if (test && recv > 0) begin
            chk({req, "/R4"}, "sdo_en in test frame", 32'(en_bits), 32'd0);
        end
        if (nbits >= 5 && !rnw && !test) begin
            for (int j = 0; j < recv && j < wid(a); j++) sh_m[a][j] = d[j];
            act_m[a] = sh_m[a];
        end
        check_outputs(req);
        chk({req, "/R10"}, "sdo_en after strobe", 32'(sdo_en), 32'd0);
    endtask

    initial begin
        for (int a = 0; a < 8; a++) begin
            sh_m[a]  = '0;
            act_m[a] = '0;
        end
        void'($urandom(32'h5EED));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_outputs("R1");
        chk("R1", "sdo_en", 32'(sdo_en), 32'd0);

        frame(0, 0, 1, 11'h2A5, 16, "R2");
        frame(0, 0, 2, 11'h7FF, 16, "R5");
        frame(0, 0, 0, 11'h7FF, 16, "R6");
        chk("R6", "op all ones", 32'(op_cfg), 32'h9F);
        frame(0, 0, 0, 11'h000, 16, "R6");
        frame(0, 0, 3, 11'h3C3, 16, "R2");
        for (int g = 0; g < 4; g++) frame(0, 0, 4 + g, 11'(7 * g + 9), 16, "R2");
        frame(0, 1, 1, 11'h155, 16, "R4");
        frame(0, 0, 1, 11'h000, 8, "R7");
        frame(0, 0, 3, 11'h7FF, 5, "R7");
        frame(0, 0, 2, 11'h000, 4, "R8");
        frame(0, 0, 2, 11'h000, 0, "R8");
        for (int a = 0; a < 8; a++) frame(1, 0, a, 11'h7FF, 16, "R11");
        frame(1, 1, 1, 11'h000, 16, "R4");
        frame(1, 0, 1, 11'h000, 9, "R9");

        for (int n = 0; n < 150; n++) begin
            bit rnw, test;
            int nb;
            rnw  = 1'($urandom_range(0, 1));
            test = ($urandom_range(0, 9) == 0);
            nb   = ($urandom_range(0, 9) < 7) ? 16 : int'($urandom_range(0, 16));
            frame(rnw, test, int'($urandom_range(0, 7)), 11'($urandom), nb,
                  rnw ? "R9" : (test ? "R4" : "R2"));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule